// File: doc/BRIEF.md
# Directory Home Agent for Line Coherence

This block is the home of a slice of the physical line space in a small system of private caches that keep their lines in Modified, Exclusive, Shared, Invalid and Forward states. A caching agent that misses sends a single request to the home that owns the line. The home is chosen by XOR-folding the line address into a home number. The home keeps an exact directory entry for each line. Each entry holds a state, a bit-vector of the agents that hold the line, and the identity of the forwarder or owner. The home snoops only the agents that entry names and gathers their answers itself. It then returns data to the requester, taken from a peer or from memory, and closes the transaction with a final acknowledgement.

The home is the single point of serialization. Accepted requests wait in a small queue and are served one at a time, in the order they arrived, so a line is never touched by two transactions at once. This also covers an atomic read-modify-write, which keeps its line locked until its acknowledgement has gone out. Agents report every eviction, including clean ones, so that the sharer vector stays exact and later snoops reach no one who has already dropped the line.

Top module: `coh_home_agent`

## Requirements
- R1: A request whose home number differs from HOME_ID is dropped. The home number is the XOR of the address split into 2-bit slices, so address bits 1:0, 3:2 and 5:4 are combined. A dropped request causes no snoop, no memory read, no data and no acknowledgement.
- R2: A read (kind 0) of a line that no agent holds reads memory, sends no snoop, and grants Exclusive (grant code 1).
- R3: A read of a line that has an owner or a forwarder other than the requester sends one share snoop (kind 0). The snoop mask names only that agent. The home returns the data from that agent's response, grants Forward (grant code 2), and does not read memory.
- R4: A write (kind 1) or atomic (kind 2) sends one invalidate snoop (kind 1) whose mask is exactly the other listed holders. The home waits for every targeted response. It takes the data from the response that carries data, or from memory if no response does, and grants Modified (grant code 3).
- R5: A read of a shared line whose forwarder has evicted reads memory, sends no snoop, and grants Forward.
- R6: An eviction (kind 3) removes the agent from the line's entry and is answered only with an acknowledgement. After an owner evicts, the next read of the line is served from memory with Exclusive.
- R7: Each non-eviction transaction gives exactly one data beat. The acknowledgement to the same agent and line follows in the very next cycle.
- R8: Requests are served one at a time, in the order they were accepted. A request to a line held by an atomic gets its data only after the atomic's acknowledgement.
- R9: At no time do two agents hold one line in Modified, Exclusive or Forward.
- R10: A snoop response from an agent the active snoop did not target is ignored, together with any data it carries.
- R11: req_ready is high when the queue has room, which includes the reset state, and low while Q_DEPTH requests are waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue has room |
| req_agent | input | AGW | Requesting agent |
| req_kind | input | 2 | 0 read, 1 write, 2 atomic, 3 evict |
| req_line | input | ADDR_W | Line address |
| snp_valid | output | 1 | Snoop pulse |
| snp_kind | output | 1 | 0 share, 1 invalidate |
| snp_mask | output | N_AG | Agents targeted |
| snp_line | output | ADDR_W | Snooped line |
| rsp_valid | input | 1 | Snoop response |
| rsp_agent | input | AGW | Responding agent |
| rsp_has_data | input | 1 | Response carries the line |
| rsp_data | input | DATA_W | Line data |
| mem_req_valid | output | 1 | Memory read pulse |
| mem_req_line | output | ADDR_W | Line to read |
| mem_rsp_valid | input | 1 | Memory data valid |
| mem_rsp_data | input | DATA_W | Memory data |
| dat_valid | output | 1 | Data to requester |
| dat_agent | output | AGW | Receiving agent |
| dat_grant | output | 2 | 1 Exclusive, 2 Forward, 3 Modified |
| dat_data | output | DATA_W | Line data |
| ack_valid | output | 1 | Final acknowledgement |
| ack_agent | output | AGW | Acknowledged agent |
| ack_line | output | ADDR_W | Acknowledged line |

## Verification
The main function is tried with a sequence of reads that moves a line from uncached, to owned, to forwarded twice. This tells apart a grant served from memory from one supplied by a peer, and checks that the forwarder role moves to the newest reader. A write against three sharers tells an exact invalidate mask apart from a broadcast. A stray response injected during a snoop shows whether untargeted answers are filtered. Eviction sequences show whether memory serves the line once the owner or the forwarder is gone. A back-to-back burst behind an atomic, followed by a long-latency burst, tells arrival-order serialization and back-pressure apart from reordering or overflow.

// File: rtl/ha_pkg.sv
package ha_pkg;
    typedef enum logic [1:0] {RQ_READ = 2'd0, RQ_WRITE = 2'd1, RQ_ATOMIC = 2'd2, RQ_EVICT = 2'd3} req_kind_e;
    typedef enum logic [1:0] {LN_INV = 2'd0, LN_SHR = 2'd1, LN_OWN = 2'd2} line_st_e;
    typedef enum logic {SN_SHARE = 1'b0, SN_INVAL = 1'b1} snp_kind_e;
    typedef enum logic [1:0] {GR_NONE = 2'd0, GR_EXCL = 2'd1, GR_FWD = 2'd2, GR_MOD = 2'd3} grant_e;
    typedef enum logic [2:0] {EN_IDLE, EN_SNOOP, EN_WAIT, EN_MEMRQ, EN_MEMWT, EN_DATA, EN_ACK} eng_e;
endpackage

// File: rtl/ha_req_fifo.sv
module ha_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] rp;
        logic [PW-1:0] wp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] slot_q [DEPTH];

    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);
    assign dout  = slot_q[ptr_q.rp];

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = (ptr_q.wp == PW'(DEPTH - 1)) ? '0 : ptr_q.wp + 1'b1;
        if (pop)  ptr_d.rp = (ptr_q.rp == PW'(DEPTH - 1)) ? '0 : ptr_q.rp + 1'b1;
        if (push && !pop) ptr_d.cnt = ptr_q.cnt + 1'b1;
        if (pop && !push) ptr_d.cnt = ptr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[ptr_q.wp] <= din;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R8
endmodule

// File: rtl/ha_dir.sv
module ha_dir #(
    parameter int N_AG   = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [1:0]        rd_st,
    output logic [N_AG-1:0]   rd_sh,
    output logic              rd_fv,
    output logic [AGW-1:0]    rd_fid,
    input  logic              we,
    input  logic [1:0]        wr_st,
    input  logic [N_AG-1:0]   wr_sh,
    input  logic              wr_fv,
    input  logic [AGW-1:0]    wr_fid
);
    localparam int AGW     = (N_AG > 1) ? $clog2(N_AG) : 1;
    localparam int N_LINES = 1 << ADDR_W;
    localparam int EW      = 2 + N_AG + 1 + AGW;

    logic [EW-1:0] ent_q [N_LINES];

    assign {rd_st, rd_sh, rd_fv, rd_fid} = ent_q[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINES; i++) ent_q[i] <= '0;
        end else if (we) begin
            ent_q[addr] <= {wr_st, wr_sh, wr_fv, wr_fid};
        end
    end

    AST_OWNER_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_st == 2'd2) |-> ($countones(wr_sh) == 1)); // R9
endmodule

// File: rtl/coh_home_agent.sv
module coh_home_agent
    import ha_pkg::*;
#(
    parameter int N_AG    = 4,
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 32,
    parameter int N_HOMES = 4,
    parameter int HOME_ID = 0,
    parameter int Q_DEPTH = 4,
    localparam int AGW    = (N_AG > 1) ? $clog2(N_AG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AGW-1:0]    req_agent,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_line,
    output logic              snp_valid,
    output logic              snp_kind,
    output logic [N_AG-1:0]   snp_mask,
    output logic [ADDR_W-1:0] snp_line,
    input  logic              rsp_valid,
    input  logic [AGW-1:0]    rsp_agent,
    input  logic              rsp_has_data,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_line,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              dat_valid,
    output logic [AGW-1:0]    dat_agent,
    output logic [1:0]        dat_grant,
    output logic [DATA_W-1:0] dat_data,
    output logic              ack_valid,
    output logic [AGW-1:0]    ack_agent,
    output logic [ADDR_W-1:0] ack_line
);
    localparam int HB  = (N_HOMES > 1) ? $clog2(N_HOMES) : 1;
    localparam int RQW = AGW + 2 + ADDR_W;

    typedef struct packed {
        eng_e              st;
        logic [AGW-1:0]    agent;
        req_kind_e         kind;
        logic [ADDR_W-1:0] line;
        snp_kind_e         sk;
        grant_e            gr;
        logic [N_AG-1:0]   pend;
        logic              got;
        logic [DATA_W-1:0] data;
    } eng_t;

    function automatic logic [HB-1:0] home_of(input logic [ADDR_W-1:0] a);
        logic [HB-1:0] h;
        h = '0;
        for (int i = 0; i < ADDR_W; i++) h[i % HB] = h[i % HB] ^ a[i];
        return h;
    endfunction

    eng_t d, q;

    // request queue: the serialization point
    logic              q_full, q_empty, q_pop, q_push;
    logic [RQW-1:0]    q_dout;
    logic [AGW-1:0]    h_agent;
    logic [1:0]        h_kind;
    logic [ADDR_W-1:0] h_line;

    assign req_ready = !q_full;
    assign q_push    = req_valid && !q_full && (home_of(req_line) == HB'(HOME_ID)); // R1
    assign {h_agent, h_kind, h_line} = q_dout;

    ha_req_fifo #(.W(RQW), .DEPTH(Q_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din({req_agent, req_kind, req_line}),
        .full(q_full), .pop(q_pop), .dout(q_dout), .empty(q_empty)
    );

    // directory
    logic [ADDR_W-1:0] dir_addr;
    logic [1:0]        rd_st, wr_st;
    logic [N_AG-1:0]   rd_sh, wr_sh;
    logic              rd_fv, wr_fv, dir_we;
    logic [AGW-1:0]    rd_fid, wr_fid;

    ha_dir #(.N_AG(N_AG), .ADDR_W(ADDR_W)) u_dir (
        .clk(clk), .rst_n(rst_n), .addr(dir_addr),
        .rd_st(rd_st), .rd_sh(rd_sh), .rd_fv(rd_fv), .rd_fid(rd_fid),
        .we(dir_we), .wr_st(wr_st), .wr_sh(wr_sh), .wr_fv(wr_fv), .wr_fid(wr_fid)
    );

    logic [AGW-1:0]  cur_agent;
    logic [N_AG-1:0] self, others;

    assign dir_addr  = (q.st == EN_IDLE) ? h_line : q.line;
    assign cur_agent = (q.st == EN_IDLE) ? h_agent : q.agent;
    assign self      = {{(N_AG-1){1'b0}}, 1'b1} << cur_agent;
    assign others    = rd_sh & ~self;

    always_comb begin
        logic [N_AG-1:0] np;
        logic            peer_held;
        d      = q;
        q_pop  = 1'b0;
        dir_we = 1'b0;
        wr_st  = rd_st;
        wr_sh  = rd_sh;
        wr_fv  = rd_fv;
        wr_fid = rd_fid;
        np     = q.pend;
        peer_held = ((rd_st == LN_OWN) || (rd_st == LN_SHR && rd_fv)) && (rd_fid != h_agent);
        unique case (q.st)
            EN_IDLE: if (!q_empty) begin
                q_pop   = 1'b1;
                d.agent = h_agent;
                d.kind  = req_kind_e'(h_kind);
                d.line  = h_line;
                d.got   = 1'b0;
                d.pend  = '0;
                unique case (req_kind_e'(h_kind))
                    RQ_EVICT: begin                               // R6
                        dir_we = 1'b1;
                        wr_sh  = rd_sh & ~self;
                        wr_fv  = rd_fv && (rd_fid != h_agent);
                        if ((rd_st == LN_OWN && rd_fid == h_agent) || (rd_sh & ~self) == '0) begin
                            wr_st = LN_INV;
                            wr_sh = '0;
                            wr_fv = 1'b0;
                        end
                        d.gr = GR_NONE;
                        d.st = EN_ACK;
                    end
                    RQ_READ: begin
                        d.sk = SN_SHARE;
                        d.gr = (others == '0) ? GR_EXCL : GR_FWD;  // R2 R5
                        if (peer_held) begin                      // R3
                            d.pend = {{(N_AG-1){1'b0}}, 1'b1} << rd_fid;
                            d.st   = EN_SNOOP;
                        end else begin
                            d.st = EN_MEMRQ;
                        end
                    end
                    default: begin                                // R4
                        d.sk   = SN_INVAL;
                        d.gr   = GR_MOD;
                        d.pend = others;
                        d.st   = (others != '0) ? EN_SNOOP : EN_MEMRQ;
                    end
                endcase
            end
            EN_SNOOP: d.st = EN_WAIT;
            EN_WAIT: begin
                if (rsp_valid && q.pend[rsp_agent]) begin         // R10
                    np[rsp_agent] = 1'b0;
                    if (rsp_has_data) begin
                        d.got  = 1'b1;
                        d.data = rsp_data;
                    end
                end
                d.pend = np;
                if (np == '0) d.st = d.got ? EN_DATA : EN_MEMRQ;
            end
            EN_MEMRQ: d.st = EN_MEMWT;
            EN_MEMWT: if (mem_rsp_valid) begin
                d.data = mem_rsp_data;
                d.st   = EN_DATA;
            end
            EN_DATA: begin
                dir_we = 1'b1;
                if (q.gr == GR_FWD) begin
                    wr_st  = LN_SHR;
                    wr_sh  = rd_sh | self;
                    wr_fv  = 1'b1;
                    wr_fid = q.agent;
                end else begin
                    wr_st  = LN_OWN;
                    wr_sh  = self;
                    wr_fv  = 1'b0;
                    wr_fid = q.agent;
                end
                d.st = EN_ACK;
            end
            EN_ACK: d.st = EN_IDLE;                               // R8
            default: d.st = EN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign snp_valid     = (q.st == EN_SNOOP);
    assign snp_kind      = q.sk;
    assign snp_mask      = q.pend;
    assign snp_line      = q.line;
    assign mem_req_valid = (q.st == EN_MEMRQ);
    assign mem_req_line  = q.line;
    assign dat_valid     = (q.st == EN_DATA);
    assign dat_agent     = q.agent;
    assign dat_grant     = q.gr;
    assign dat_data      = q.data;
    assign ack_valid     = (q.st == EN_ACK);
    assign ack_agent     = q.agent;
    assign ack_line      = q.line;

    AST_ACK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |=> ack_valid); // R7
    AST_ACK_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && q.kind != RQ_EVICT) |-> $past(dat_valid)); // R7
    AST_SNOOP_SKIPS_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !snp_mask[q.agent]); // R3
    AST_SNOOP_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> (snp_mask != '0)); // R4
endmodule

// File: tb/coh_home_agent_bench.sv
`timescale 1ns/1ps
module coh_home_agent_bench;
    localparam int NA = 4;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int K_RD = 0, K_WR = 1, K_AT = 2, K_EV = 3;
    localparam int G_E = 1, G_F = 2, G_M = 3;
    localparam int S_I = 0, S_S = 1, S_E = 2, S_F = 3, S_M = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_agent = '0, req_kind = '0;
    logic [AW-1:0] req_line = '0;
    logic snp_valid, snp_kind;
    logic [NA-1:0] snp_mask;
    logic [AW-1:0] snp_line;
    logic rsp_valid = 1'b0, rsp_has_data = 1'b0;
    logic [1:0] rsp_agent = '0;
    logic [DW-1:0] rsp_data = '0;
    logic mem_req_valid;
    logic [AW-1:0] mem_req_line;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic dat_valid, ack_valid;
    logic [1:0] dat_agent, dat_grant, ack_agent;
    logic [DW-1:0] dat_data;
    logic [AW-1:0] ack_line;

    always #10 clk = ~clk;

    coh_home_agent u_coh_home_agent (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_agent(req_agent),
        .req_kind(req_kind), .req_line(req_line),
        .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_mask(snp_mask), .snp_line(snp_line),
        .rsp_valid(rsp_valid), .rsp_agent(rsp_agent), .rsp_has_data(rsp_has_data), .rsp_data(rsp_data),
        .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .dat_valid(dat_valid), .dat_agent(dat_agent), .dat_grant(dat_grant), .dat_data(dat_data),
        .ack_valid(ack_valid), .ack_agent(ack_agent), .ack_line(ack_line)
    );

    typedef struct {
        int agent; int line; bit evict; int grant; logic [DW-1:0] data;
        int sup; logic [NA-1:0] mask; bit skind; bit from_mem; int rq;
    } item_t;

    item_t exp_q[$];
    int em [NA][64];
    int eo [NA][64];
    logic [DW-1:0] cdata [NA][64];
    int n_chk = 0, n_fail = 0;
    int n_dat = 0, n_ack = 0, n_snp = 0, n_mem = 0;
    int mem_delay = 2;
    bit stray_en = 0, saw_full = 0, ack_due = 0;
    int ack_a, ack_l;

    function automatic logic [DW-1:0] memf(int ln);
        return 32'h5A00_0000 | DW'(ln);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input int a, input int k, input int ln, input int rq, input bit foreign = 0);
        item_t it;
        int others;
        if (!foreign) begin
            it.agent = a; it.line = ln; it.rq = rq; it.evict = (k == K_EV);
            it.sup = -1; others = 0; it.mask = '0; it.grant = 0; it.data = '0;
            it.skind = 0; it.from_mem = 0;
            for (int p = 0; p < NA; p++) if (p != a) begin
                if (em[p][ln] != S_I) others |= (1 << p);
                if (em[p][ln] >= S_E) it.sup = p;
            end
            if (it.evict) begin
                em[a][ln] = S_I;
            end else begin
                it.data = (it.sup >= 0) ? cdata[it.sup][ln] : memf(ln);
                it.from_mem = (it.sup < 0);
                if (k == K_RD) begin
                    it.grant = (others != 0) ? G_F : G_E;
                    it.mask = (it.sup >= 0) ? NA'(1 << it.sup) : '0;
                    it.skind = 0;
                    if (it.sup >= 0) em[it.sup][ln] = S_S;
                    for (int p = 0; p < NA; p++) if (p != a && em[p][ln] == S_F) em[p][ln] = S_S;
                    em[a][ln] = (it.grant == G_F) ? S_F : S_E;
                    cdata[a][ln] = it.data;
                end else begin
                    it.grant = G_M; it.mask = NA'(others); it.skind = 1;
                    for (int p = 0; p < NA; p++) if (p != a) em[p][ln] = S_I;
                    em[a][ln] = S_M;
                    cdata[a][ln] = it.data + 32'h11;
                end
            end
            exp_q.push_back(it);
        end
        req_valid = 1'b1; req_agent = 2'(a); req_kind = 2'(k); req_line = AW'(ln);
        while (!req_ready) begin saw_full = 1; @(negedge clk); end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || ack_due) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // snoop responder: answers each targeted agent, one per cycle
    always begin
        logic [NA-1:0] m;
        int sup; logic [DW-1:0] sd;
        @(negedge clk);
        if (rst_n && snp_valid) begin
            m = snp_mask; sup = -1; sd = '0;
            if (exp_q.size() != 0) begin sup = exp_q[0].sup; sd = exp_q[0].data; end
            @(negedge clk);
            if (stray_en) begin
                for (int p = NA - 1; p >= 0; p--) if (!m[p]) rsp_agent = 2'(p);
                rsp_valid = 1'b1; rsp_has_data = 1'b1; rsp_data = 32'hDEAD_BEEF;
                @(negedge clk);
            end
            for (int p = 0; p < NA; p++) if (m[p]) begin
                rsp_valid = 1'b1; rsp_agent = 2'(p);
                rsp_has_data = (p == sup); rsp_data = (p == sup) ? sd : '0;
                @(negedge clk);
            end
            rsp_valid = 1'b0; rsp_has_data = 1'b0;
        end
    end

    // memory responder
    always begin
        logic [AW-1:0] ln;
        @(negedge clk);
        if (rst_n && mem_req_valid) begin
            ln = mem_req_line;
            repeat (mem_delay) @(negedge clk);
            mem_rsp_valid = 1'b1; mem_rsp_data = memf(int'(ln));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        item_t it;
        int holders;
        if (rst_n) begin
            if (snp_valid) begin
                n_snp++;
                if (exp_q.size() == 0) chk(0, "R1", "snoop with no transaction", 1, 0);
                else begin
                    it = exp_q[0];
                    chk(snp_mask == it.mask, $sformatf("R%0d", it.rq), "snoop mask", snp_mask, it.mask);
                    chk(snp_kind == it.skind, $sformatf("R%0d", it.rq), "snoop kind", snp_kind, it.skind);
                    chk(snp_line == AW'(it.line), $sformatf("R%0d", it.rq), "snoop line", snp_line, it.line);
                end
                for (int p = 0; p < NA; p++) if (snp_mask[p]) begin
                    if (snp_kind) eo[p][snp_line] = S_I;
                    else if (eo[p][snp_line] >= S_E) eo[p][snp_line] = S_S;
                end
            end
            if (mem_req_valid) begin
                n_mem++;
                if (exp_q.size() == 0) chk(0, "R1", "memory read with no transaction", 1, 0);
                else chk(exp_q[0].from_mem && mem_req_line == AW'(exp_q[0].line),
                         $sformatf("R%0d", exp_q[0].rq), "memory read line", mem_req_line, exp_q[0].line);
            end
            if (ack_valid) begin
                n_ack++;
                if (ack_due) begin
                    chk(ack_agent == 2'(ack_a) && ack_line == AW'(ack_l), "R7", "ack agent/line",
                        {ack_agent, ack_line}, {2'(ack_a), AW'(ack_l)});
                    ack_due = 0;
                end else if (exp_q.size() != 0 && exp_q[0].evict) begin
                    it = exp_q.pop_front();
                    chk(ack_agent == 2'(it.agent) && ack_line == AW'(it.line), "R6", "evict ack",
                        {ack_agent, ack_line}, {2'(it.agent), AW'(it.line)});
                    eo[it.agent][it.line] = S_I;
                end else chk(0, "R7", "unexpected ack", 1, 0);
            end else if (ack_due) begin
                chk(0, "R7", "ack missing after data", 0, 1);
                ack_due = 0;
            end
            if (dat_valid) begin
                n_dat++;
                if (exp_q.size() == 0 || exp_q[0].evict) chk(0, "R8", "unexpected data", 1, 0);
                else begin
                    it = exp_q.pop_front();
                    chk(dat_agent == 2'(it.agent), "R8", "data order agent", dat_agent, it.agent);
                    chk(dat_grant == 2'(it.grant), $sformatf("R%0d", it.rq), "grant", dat_grant, it.grant);
                    chk(dat_data == it.data, $sformatf("R%0d", it.rq), "data", dat_data, it.data);
                    eo[dat_agent][it.line] = (dat_grant == 2'(G_E)) ? S_E : (dat_grant == 2'(G_F)) ? S_F : S_M;
                    for (int p = 0; p < NA; p++)
                        if (p != int'(dat_agent) && dat_grant == 2'(G_F) && eo[p][it.line] == S_F) eo[p][it.line] = S_S;
                    holders = 0;
                    for (int p = 0; p < NA; p++) if (eo[p][it.line] >= S_E) holders++;
                    chk(holders <= 1, "R9", "M/E/F holders of line", holders, 1);
                    ack_due = 1; ack_a = it.agent; ack_l = it.line;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int s_dat, s_ack, s_snp, s_mem;
        for (int p = 0; p < NA; p++) for (int l = 0; l < 64; l++) begin
            em[p][l] = S_I; eo[p][l] = S_I; cdata[p][l] = '0;
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
        chk({dat_valid, ack_valid, snp_valid, mem_req_valid} == 4'b0, "R7", "outputs idle in reset",
            {dat_valid, ack_valid, snp_valid, mem_req_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(0, K_RD, 5, 2); drain();            // R2 uncached read
        issue(1, K_RD, 5, 3); drain();            // R3 owner supplies
        stray_en = 1;
        issue(2, K_RD, 5, 10); drain();           // R10 stray answer during forwarder snoop
        stray_en = 0;
        issue(3, K_WR, 5, 4); drain();            // R4 invalidate three sharers

        issue(0, K_RD, 10, 2); drain();
        issue(0, K_EV, 10, 6); drain();           // R6 owner evicts
        issue(1, K_RD, 10, 6); drain();

        issue(0, K_RD, 15, 2); drain();
        issue(1, K_RD, 15, 3); drain();
        issue(1, K_EV, 15, 6); drain();
        issue(2, K_RD, 15, 5); drain();           // R5 no forwarder left

        s_dat = n_dat; s_ack = n_ack; s_snp = n_snp; s_mem = n_mem;
        issue(0, K_RD, 1, 1, 1'b1);               // R1 foreign home
        repeat (30) @(negedge clk);
        chk(n_dat == s_dat && n_ack == s_ack && n_snp == s_snp && n_mem == s_mem, "R1",
            "activity for foreign line", (n_dat + n_ack + n_snp + n_mem), (s_dat + s_ack + s_snp + s_mem));

        issue(0, K_AT, 17, 4);                    // R8 atomic then queued requests
        issue(1, K_RD, 17, 8);
        issue(2, K_RD, 20, 8);
        issue(3, K_WR, 17, 8);
        drain();

        mem_delay = 40; saw_full = 0;
        issue(3, K_RD, 27, 11); issue(3, K_RD, 30, 11); issue(3, K_RD, 34, 11);
        issue(3, K_RD, 40, 11); issue(3, K_RD, 45, 11); issue(3, K_RD, 51, 11);
        chk(saw_full == 1, "R11", "ready dropped with queue full", saw_full, 1);
        drain();
        mem_delay = 2;
        chk(req_ready == 1'b1, "R11", "ready after drain", req_ready, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule